// File: doc/BRIEF.md
# Active Fuzzy Rule Address Selector

This block finds which fuzzy rules an input set can fire and issues only those rules' addresses. Four 7-bit inputs enter on a start pulse. Each input is tested against the start and end points of its seven fuzzy sets, which software loads beforehand. At most two neighbouring sets overlap at any input value, so each input yields a lowest active set and possibly the set just above it.

The block then walks a fixed sequence of sixteen beats, one per clock. Each beat picks, for every input, either its lowest active set or the set above it. From that choice it forms a rule-memory address as a mixed-radix number over the set indices, which is why the rule memory never stores premise sets. On the same beat it gives the four membership-shape addresses. A beat that names a set which is not actually active is still issued, but is flagged as not live. This keeps the downstream cycle count constant.

Top module: `activeRuleSel`

## Requirements
- R1: After reset, ruleValid, ruleLive, done and busy are all low.
- R2: After reset every fuzzy set is empty (start point 127, end point 0), so a run made before any bound is written issues sixteen beats that are all not live.
- R3: A start seen while idle latches inData. The first beat appears on the second clock after that edge, and changes on inData after the latching edge do not affect the run.
- R4: Each accepted start yields exactly sixteen consecutive cycles with ruleValid high.
- R5: On beat n (0 to 15), input k takes its lowest active set when bit (3-k) of n is 0, and the set one above it when that bit is 1.
- R6: ruleAddr equals ((i0*7 + i1)*7 + i2)*7 + i3, where ik is the set index chosen for input k. It lies in 0 to 2400.
- R7: mfAddr holds four 5-bit fields. The field at bits [5k+4:5k] equals k*7 + ik.
- R8: A set s of input k is active when its start point is at most x and x is at most its end point. The lowest active set is the base. A second set exists when set base+1 is also active.
- R9: ruleLive is low on a beat when any input has no active set, or when the beat asks for the upper set of an input that has only one. In that case the index used is the base, or 0 when nothing is active.
- R10: done is high for exactly one cycle, the cycle right after the last beat.
- R11: start is ignored while busy, including the done cycle. busy falls on the cycle after done.
- R12: A cycle with cfgWr high writes cfgLo and cfgHi as the start and end points of set cfgSet of input cfgVar. The write applies to every later run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run on the current inData |
| inData | input | 28 | Input k in bits [7k+6:7k] |
| cfgWr | input | 1 | Bound write strobe |
| cfgVar | input | 2 | Input whose set is written |
| cfgSet | input | 3 | Set index written (0 to 6) |
| cfgLo | input | 7 | Start point of the set |
| cfgHi | input | 7 | End point of the set |
| busy | output | 1 | A run is in progress |
| ruleValid | output | 1 | A beat is being issued |
| ruleLive | output | 1 | The issued beat is a real active rule |
| ruleAddr | output | 12 | Rule-memory address |
| mfAddr | output | 20 | Four membership-shape addresses |
| done | output | 1 | Pulse after the last beat |

## Verification
Several internal faults show up at the ports within a single run. A wrong base or second-set flag in the compare registers gives a wrong address or live flag on the very first beat whose select bit touches that input, at most eight beats into the walk. A fault in the beat counter or state register shows as a run that is not exactly sixteen beats long, or as a done pulse that is missing or misplaced. An unstable input latch appears as addresses that follow inData after the start edge, and this is exposed by changing inData during a run.

// File: rtl/ruleSelPkg.sv
package ruleSelPkg;

  typedef enum logic [1:0] {
    SEL_IDLE  = 2'd0,
    SEL_CMP   = 2'd1,
    SEL_ISSUE = 2'd2,
    SEL_DONE  = 2'd3
  } selState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchIn;
    logic capture;
    logic issue;
  } selStrobe_t;

endpackage

// File: rtl/ruleSelBounds.sv
module ruleSelBounds #(
  parameter int DATA_W   = 7,
  parameter int NUM_SETS = 7,
  parameter int VAR_W    = 2,
  parameter int VAR_ID   = 0,
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic [VAR_W-1:0]  cfgVar,
  input  logic [SET_W-1:0]  cfgSet,
  input  logic [DATA_W-1:0] cfgLo,
  input  logic [DATA_W-1:0] cfgHi,
  input  logic [DATA_W-1:0] x,
  output logic [SET_W-1:0]  loIdx,
  output logic              twoSets,
  output logic              anyHit
);

  logic [DATA_W-1:0] loB [NUM_SETS];
  logic [DATA_W-1:0] hiB [NUM_SETS];
  logic [NUM_SETS:0] hitExt;

  // bound registers for this input, reset to empty intervals
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        loB[s] <= '1;
        hiB[s] <= '0;
      end
    end else if (cfgWr && cfgVar == VAR_W'(VAR_ID)) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        if (cfgSet == SET_W'(s)) begin
          loB[s] <= cfgLo;
          hiB[s] <= cfgHi;
        end
      end
    end
  end

  // one interval test per set
  for (genvar s = 0; s < NUM_SETS; s++) begin : g_hit
    assign hitExt[s] = (loB[s] <= x) && (x <= hiB[s]);
  end
  assign hitExt[NUM_SETS] = 1'b0;

  // lowest hit wins; its upper neighbour decides the second set
  always_comb begin
    loIdx   = '0;
    twoSets = 1'b0;
    for (int s = NUM_SETS - 1; s >= 0; s--) begin
      if (hitExt[s]) begin
        loIdx   = SET_W'(s);
        twoSets = hitExt[s+1];
      end
    end
  end

  assign anyHit = |hitExt[NUM_SETS-1:0];

  p_two_has_base_r8: assert property (@(posedge clk) disable iff (!rstN)
    twoSets |-> (anyHit && (32'(loIdx) < NUM_SETS - 1)));

endmodule

// File: rtl/ruleSelCtrl.sv
module ruleSelCtrl
  import ruleSelPkg::*;
#(
  parameter int NUM_IN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output selStrobe_t        strb,
  output logic [NUM_IN-1:0] beat,
  output logic              busy,
  output logic              done
);

  localparam logic [NUM_IN-1:0] LAST_BEAT = '1;

  selState_e         state;
  logic [NUM_IN-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= SEL_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        SEL_IDLE:  if (start) state <= SEL_CMP;
        SEL_CMP: begin
          state <= SEL_ISSUE;
          cnt   <= '0;
        end
        SEL_ISSUE: begin
          if (cnt == LAST_BEAT) state <= SEL_DONE;
          else                  cnt   <= cnt + 1'b1;
        end
        SEL_DONE:  state <= SEL_IDLE;
        default:   state <= SEL_IDLE;
      endcase
    end
  end

  always_comb begin
    strb         = '0;
    strb.latchIn = (state == SEL_IDLE) && start;
    strb.capture = (state == SEL_CMP);
    strb.issue   = (state == SEL_ISSUE);
  end

  assign beat = cnt;
  assign busy = (state != SEL_IDLE);
  assign done = (state == SEL_DONE);

  p_start_to_cmp_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEL_IDLE && start) |=> (busy && !strb.issue));
  p_run_continues_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issue && cnt != LAST_BEAT) |=> strb.issue);
  p_done_after_last_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issue && cnt == LAST_BEAT) |=> (done && !strb.issue));
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_idle_after_done_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

endmodule

// File: rtl/ruleSelDatapath.sv
module ruleSelDatapath
  import ruleSelPkg::*;
#(
  parameter int NUM_IN   = 4,
  parameter int DATA_W   = 7,
  parameter int NUM_SETS = 7,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int VAR_W   = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int TOTAL   = NUM_SETS ** NUM_IN,
  localparam int ADDR_W  = $clog2(TOTAL),
  localparam int MF_W    = $clog2(NUM_IN * NUM_SETS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  selStrobe_t               strb,
  input  logic [NUM_IN-1:0]        beat,
  input  logic [NUM_IN*DATA_W-1:0] inData,
  input  logic                     cfgWr,
  input  logic [VAR_W-1:0]         cfgVar,
  input  logic [SET_W-1:0]         cfgSet,
  input  logic [DATA_W-1:0]        cfgLo,
  input  logic [DATA_W-1:0]        cfgHi,
  output logic                     ruleLive,
  output logic [ADDR_W-1:0]        ruleAddr,
  output logic [NUM_IN*MF_W-1:0]   mfAddr
);

  logic [NUM_IN*DATA_W-1:0] held;
  logic [SET_W-1:0] loW   [NUM_IN];
  logic [SET_W-1:0] loReg [NUM_IN];
  logic [SET_W-1:0] idx   [NUM_IN];
  logic [NUM_IN-1:0] twoW, hitW, twoReg, hitReg, liveK;

  always_ff @(posedge clk) begin
    if (!rstN)             held <= '0;
    else if (strb.latchIn) held <= inData;
  end

  for (genvar k = 0; k < NUM_IN; k++) begin : g_var
    localparam int BASE = k * NUM_SETS;
    logic pick;

    ruleSelBounds #(
      .DATA_W  (DATA_W),
      .NUM_SETS(NUM_SETS),
      .VAR_W   (VAR_W),
      .VAR_ID  (k)
    ) u_bounds (
      .clk    (clk),
      .rstN   (rstN),
      .cfgWr  (cfgWr),
      .cfgVar (cfgVar),
      .cfgSet (cfgSet),
      .cfgLo  (cfgLo),
      .cfgHi  (cfgHi),
      .x      (held[k*DATA_W +: DATA_W]),
      .loIdx  (loW[k]),
      .twoSets(twoW[k]),
      .anyHit (hitW[k])
    );

    always_ff @(posedge clk) begin
      if (!rstN) begin
        loReg[k]  <= '0;
        twoReg[k] <= 1'b0;
        hitReg[k] <= 1'b0;
      end else if (strb.capture) begin
        loReg[k]  <= loW[k];
        twoReg[k] <= twoW[k];
        hitReg[k] <= hitW[k];
      end
    end

    // input 0 sits on the most significant beat bit
    assign pick     = beat[NUM_IN-1-k];
    assign idx[k]   = loReg[k] + SET_W'(pick & twoReg[k]);
    assign liveK[k] = hitReg[k] && (!pick || twoReg[k]);
    assign mfAddr[k*MF_W +: MF_W] = MF_W'(BASE) + MF_W'(idx[k]);

    p_mf_range_r7: assert property (@(posedge clk) disable iff (!rstN)
      strb.issue |-> (32'(mfAddr[k*MF_W +: MF_W]) < BASE + NUM_SETS));
  end

  // mixed-radix rule address, input 0 most significant
  always_comb begin
    ruleAddr = '0;
    for (int k = 0; k < NUM_IN; k++)
      ruleAddr = ADDR_W'(ruleAddr * ADDR_W'(NUM_SETS)) + ADDR_W'(idx[k]);
  end

  assign ruleLive = strb.issue && (&liveK);

  p_latch_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issue && $past(strb.issue)) |-> $stable(held));
  p_addr_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |-> (32'(ruleAddr) < TOTAL));
  p_live_in_beat_r9: assert property (@(posedge clk) disable iff (!rstN)
    ruleLive |-> (&hitReg));

endmodule

// File: rtl/activeRuleSel.sv
module activeRuleSel
  import ruleSelPkg::*;
#(
  parameter int NUM_IN   = 4,
  parameter int DATA_W   = 7,
  parameter int NUM_SETS = 7,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int VAR_W   = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int ADDR_W  = $clog2(NUM_SETS ** NUM_IN),
  localparam int MF_W    = $clog2(NUM_IN * NUM_SETS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [NUM_IN*DATA_W-1:0] inData,
  input  logic                     cfgWr,
  input  logic [VAR_W-1:0]         cfgVar,
  input  logic [SET_W-1:0]         cfgSet,
  input  logic [DATA_W-1:0]        cfgLo,
  input  logic [DATA_W-1:0]        cfgHi,
  output logic                     busy,
  output logic                     ruleValid,
  output logic                     ruleLive,
  output logic [ADDR_W-1:0]        ruleAddr,
  output logic [NUM_IN*MF_W-1:0]   mfAddr,
  output logic                     done
);

  selStrobe_t        strb;
  logic [NUM_IN-1:0] beat;

  ruleSelCtrl #(.NUM_IN(NUM_IN)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .strb (strb),
    .beat (beat),
    .busy (busy),
    .done (done)
  );

  ruleSelDatapath #(
    .NUM_IN  (NUM_IN),
    .DATA_W  (DATA_W),
    .NUM_SETS(NUM_SETS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .beat    (beat),
    .inData  (inData),
    .cfgWr   (cfgWr),
    .cfgVar  (cfgVar),
    .cfgSet  (cfgSet),
    .cfgLo   (cfgLo),
    .cfgHi   (cfgHi),
    .ruleLive(ruleLive),
    .ruleAddr(ruleAddr),
    .mfAddr  (mfAddr)
  );

  assign ruleValid = strb.issue;

endmodule

// File: tb/activeRuleSel_test.sv
`timescale 1ns/1ps
module activeRuleSel_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [27:0] inData = '0;
  logic        cfgWr = 1'b0;
  logic [1:0]  cfgVar = '0;
  logic [2:0]  cfgSet = '0;
  logic [6:0]  cfgLo = '0, cfgHi = '0;
  logic        busy, ruleValid, ruleLive, done;
  logic [11:0] ruleAddr;
  logic [19:0] mfAddr;

  int checks = 0;
  int fails  = 0;
  int mLo [4][7];
  int mHi [4][7];

  always #4 clk = ~clk;

  activeRuleSel uut (
    .clk(clk), .rstN(rstN), .start(start), .inData(inData),
    .cfgWr(cfgWr), .cfgVar(cfgVar), .cfgSet(cfgSet), .cfgLo(cfgLo), .cfgHi(cfgHi),
    .busy(busy), .ruleValid(ruleValid), .ruleLive(ruleLive),
    .ruleAddr(ruleAddr), .mfAddr(mfAddr), .done(done)
  );

  typedef struct packed {
    logic [6:0] a, b, c, d;
    logic [4:0] live;
    logic [11:0] first;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{7'd5,   7'd5,   7'd5,   7'd5,   5'd1,  12'd0},
    '{7'd20,  7'd20,  7'd20,  7'd20,  5'd16, 12'd0},
    '{7'd20,  7'd5,   7'd40,  7'd100, 5'd4,  12'd19},
    '{7'd127, 7'd127, 7'd127, 7'd127, 5'd1,  12'd2400},
    '{7'd16,  7'd23,  7'd24,  7'd0,   5'd4,  12'd7}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeBound(input int v, input int s, input int lo, input int hi);
    @(negedge clk);
    cfgWr = 1'b1; cfgVar = 2'(v); cfgSet = 3'(s); cfgLo = 7'(lo); cfgHi = 7'(hi);
    @(negedge clk);
    cfgWr = 1'b0;
    mLo[v][s] = lo; mHi[v][s] = hi;
  endtask

  // R8 reference: base set, second set, any hit
  task automatic modelVar(input int k, input int x, output int lo, output bit two, output bit hit);
    lo = 0; two = 0; hit = 0;
    for (int s = 6; s >= 0; s--) begin
      if (mLo[k][s] <= x && x <= mHi[k][s]) begin
        lo = s; hit = 1;
        two = (s < 6) && (mLo[k][s+1] <= x && x <= mHi[k][s+1]);
      end
    end
  endtask

  function automatic logic [27:0] pack4(input logic [6:0] a, b, c, d);
    return {d, c, b, a};
  endfunction

  task automatic runSet(input logic [27:0] dIn, input bit disturb,
                        output int liveCnt, output int firstAddr);
    int lo [4];
    bit two [4];
    bit hit [4];
    for (int k = 0; k < 4; k++) modelVar(k, int'(dIn[k*7 +: 7]), lo[k], two[k], hit[k]);
    liveCnt = 0; firstAddr = -1;
    @(negedge clk);
    inData = dIn; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !ruleValid, "R3 latency (compare cycle)", int'(ruleValid), 0);
    if (disturb) inData = ~dIn;
    @(negedge clk);
    for (int n = 0; n < 16; n++) begin
      int expAddr = 0;
      bit expLive = 1;
      bit mfOk = 1;
      for (int k = 0; k < 4; k++) begin
        int b = (n >> (3 - k)) & 1;
        int ix = lo[k] + ((b == 1 && two[k]) ? 1 : 0);
        expAddr = expAddr * 7 + ix;
        if (!hit[k] || (b == 1 && !two[k])) expLive = 0;
        if (int'(mfAddr[k*5 +: 5]) != k * 7 + ix) mfOk = 0;
      end
      chk(ruleValid, "R4 beat valid", int'(ruleValid), 1);
      chk(int'(ruleAddr) == expAddr, "R5/R6 rule address", int'(ruleAddr), expAddr);
      chk(mfOk, "R7 shape addresses", int'(mfAddr), n);
      chk(ruleLive == expLive, "R9 live flag", int'(ruleLive), int'(expLive));
      if (ruleLive) liveCnt++;
      if (n == 0) firstAddr = int'(ruleAddr);
      if (disturb && n == 5) start = 1'b1;
      if (disturb && n == 6) start = 1'b0;
      @(negedge clk);
    end
    chk(done && !ruleValid, "R10 done after last beat", int'(done), 1);
    if (disturb) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!done && !busy && !ruleValid, "R11 idle after done, start ignored", int'(busy), 0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lc, fa;
    for (int v = 0; v < 4; v++)
      for (int s = 0; s < 7; s++) begin
        mLo[v][s] = 127; mHi[v][s] = 0;
      end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    chk(!ruleValid && !ruleLive && !done && !busy, "R1 reset outputs", int'(busy), 0);

    // R2: empty bounds after reset
    runSet(pack4(7'd5, 7'd50, 7'd90, 7'd127), 1'b0, lc, fa);
    chk(lc == 0, "R2 empty sets give no live beat", lc, 0);

    // R12: load overlapping layout
    for (int v = 0; v < 4; v++)
      for (int s = 0; s < 7; s++)
        writeBound(v, s, s * 16, (s == 6) ? 127 : s * 16 + 23);

    // table of vectors
    for (int i = 0; i < 5; i++) begin
      runSet(pack4(VECS[i].a, VECS[i].b, VECS[i].c, VECS[i].d), 1'b0, lc, fa);
      chk(lc == int'(VECS[i].live), "R8 live beat count", lc, int'(VECS[i].live));
      chk(fa == int'(VECS[i].first), "R6 first address", fa, int'(VECS[i].first));
    end

    // R3/R11: input changes and stray starts during a run
    runSet(pack4(7'd20, 7'd5, 7'd40, 7'd100), 1'b1, lc, fa);
    chk(lc == 4, "R3 latched inputs hold", lc, 4);

    // R12/R9: carve a hole so input 1 has no active set
    writeBound(1, 0, 10, 12);
    runSet(pack4(7'd5, 7'd5, 7'd5, 7'd5), 1'b0, lc, fa);
    chk(lc == 0, "R9 missing input gives no live beat", lc, 0);
    writeBound(1, 0, 0, 23);
    runSet(pack4(7'd5, 7'd5, 7'd5, 7'd5), 1'b0, lc, fa);
    chk(lc == 1, "R12 rewritten bound applies", lc, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule